// File: doc/BRIEF.md
# Command Flag Decoder and Checked Block Framer

This block sits between a single-wire token layer and a command engine. In its idle state it reads each incoming byte as an 8-bit flag. One flag value opens a command block. One asks the block to send back the current reply. One puts the device to sleep. Every other value is dropped without effect.

A command block opens with a length byte. That byte counts the whole block: itself, the packet and the two check bytes that close it. The block verifies the length, runs a 16-bit CRC over the length and packet bytes and compares it with the trailing pair. If the block is sound, it passes the packet to the engine with a one-cycle strobe.

Replies go out with the same framing, one byte per ready handshake. A reply is either the engine's output packet or one of three fixed status bytes: wake, execution error or framing error. A reply stays available and can be read again any number of times until a new command, a sleep or a wake replaces it.

Top module: `cmd_block_framer`

## Requirements
- R1: After reset `tx_valid_o`, `pkt_valid_o` and `sleep_o` are low, and a transmit flag (0x99) produces no output until `wake_i` has been pulsed.
- R2: After a `wake_i` pulse, a transmit flag returns the block 0x04, 0x11, CRC low, CRC high.
- R3: In the idle state, any byte other than 0x66, 0x99 and 0xCC is ignored: no output byte, no packet strobe and no sleep pulse follows.
- R4: After flag 0x66, a block with a length byte from 4 to 39 and a correct CRC raises `pkt_valid_o` for exactly one cycle. With that strobe, `pkt_len_o` equals the length minus 3, and packet byte k appears at `pkt_data_o[8k+7:8k]`.
- R5: The CRC uses polynomial 0x8005 with initial value 0. It is fed bit-serially, least significant bit of each byte first, over the length byte and the packet bytes. The low CRC byte travels before the high byte, in both directions.
- R6: A block whose CRC does not match gives no packet strobe, and the next transmit flag returns a block whose single status byte is 0xFF.
- R7: A length byte below 4 or above 39 ends reception at once. The next byte is decoded as a flag, and a transmit flag returns status 0xFF.
- R8: Once a command has been accepted and until the engine reports back, transmit flags are ignored. This includes a flag that arrives in the same cycle as the engine's report.
- R9: `exec_err_i` pulsed while a command is pending makes the reply a block with status 0x0F.
- R10: `rsp_valid_i` pulsed while a command is pending makes the reply a block of length `rsp_len_i` + 3, holding the bytes of `rsp_data_i` (byte 0 in bits 7:0, `rsp_len_i` from 1 to RSP_MAX). Each later transmit flag resends the identical block.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_byte_o` stays unchanged.
- R12: Input bytes that arrive while a reply is being sent are ignored, flags included.
- R13: Flag 0xCC raises `sleep_o` for one cycle, in the cycle after the flag is taken. After that, transmit flags are ignored until the next wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_i | input | 1 | Wake token seen by the token layer; takes priority over all else |
| rx_byte_i | input | 8 | Byte received from the token layer |
| rx_valid_i | input | 1 | One-cycle strobe for `rx_byte_i` |
| tx_byte_o | output | 8 | Reply byte to the token layer |
| tx_valid_o | output | 1 | `tx_byte_o` is offered |
| tx_ready_i | input | 1 | Token layer takes `tx_byte_o` this cycle |
| pkt_data_o | output | 288 | Received packet, byte k in bits 8k+7:8k |
| pkt_len_o | output | 6 | Number of packet bytes |
| pkt_valid_o | output | 1 | One-cycle strobe: a checked packet is ready |
| rsp_data_i | input | 32 | Engine output packet, byte 0 in bits 7:0 |
| rsp_len_i | input | 3 | Engine output length in bytes (1 to 4) |
| rsp_valid_i | input | 1 | Engine finished; output packet is valid |
| exec_err_i | input | 1 | Engine rejected the command |
| sleep_o | output | 1 | One-cycle pulse: sleep flag received |

## Verification
The engine's completion strobe and an incoming transmit flag can land on the same clock edge. The flag is judged against the reply state held before that edge, so it must be dropped even though the result arrives in the same cycle. The bench drives `rsp_valid_i` in the cycle that carries the 0x99 byte. It then checks that no reply byte appears for a while, and that the next transmit flag alone brings out the full response block.

// File: rtl/frm_pkg.sv
package frm_pkg;

    localparam int BLK_MIN = 4;
    localparam int BLK_MAX = 39;
    localparam int OVH     = 3;

    localparam logic [7:0] FLG_CMD = 8'h66;
    localparam logic [7:0] FLG_XMT = 8'h99;
    localparam logic [7:0] FLG_SLP = 8'hCC;

    localparam logic [7:0] ST_WAKE = 8'h11;
    localparam logic [7:0] ST_EXEC = 8'h0F;
    localparam logic [7:0] ST_COMM = 8'hFF;

    localparam logic [15:0] CRC_POLY = 16'h8005;

    typedef enum logic [1:0] {RPL_NONE, RPL_WAIT, RPL_READY} rpl_e;
    typedef enum logic [1:0] {RXE_NONE, RXE_GOOD, RXE_BAD} rx_evt_e;

    // one byte through the serial CRC, least significant bit first
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[15] ^ b[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/frm_rx.sv
module frm_rx
    import frm_pkg::*;
#(
    parameter int MIN_LEN = BLK_MIN,
    parameter int MAX_LEN = BLK_MAX,
    localparam int PKT_MAX = MAX_LEN - OVH,
    localparam int PIDX_W  = $clog2(PKT_MAX),
    localparam int PLEN_W  = $clog2(PKT_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear_i,
    input  logic                  start_i,
    input  logic [7:0]            byte_i,
    input  logic                  valid_i,
    output logic                  active_o,
    output rx_evt_e               evt_o,
    output logic [PLEN_W-1:0]     len_o,
    output logic [PKT_MAX*8-1:0]  data_o
);

    logic [7:0]  idx_q;
    logic [7:0]  cnt_q;
    logic [7:0]  lo_q;
    logic [15:0] crc_q;
    logic [7:0]  mem_q [PKT_MAX];
    logic        in_pkt;
    logic [PIDX_W-1:0] widx;

    always_comb begin
        in_pkt = (idx_q != 8'd0) && (idx_q <= cnt_q - 8'd3);
        widx   = PIDX_W'(idx_q - 8'd1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            active_o <= 1'b0;
            evt_o    <= RXE_NONE;
            idx_q    <= '0;
            cnt_q    <= '0;
            lo_q     <= '0;
            crc_q    <= '0;
            len_o    <= '0;
        end else begin
            evt_o <= RXE_NONE;
            if (start_i) begin
                active_o <= 1'b1;
                idx_q    <= '0;
                crc_q    <= '0;
            end else if (active_o && valid_i) begin
                if (idx_q == 8'd0) begin
                    cnt_q <= byte_i;
                    if (byte_i < 8'(MIN_LEN) || byte_i > 8'(MAX_LEN)) begin
                        active_o <= 1'b0;
                        evt_o    <= RXE_BAD;
                    end else begin
                        crc_q <= crc16_step(16'h0000, byte_i);
                        idx_q <= 8'd1;
                    end
                end else if (in_pkt) begin
                    crc_q <= crc16_step(crc_q, byte_i);
                    idx_q <= idx_q + 8'd1;
                end else if (idx_q == cnt_q - 8'd2) begin
                    lo_q  <= byte_i;
                    idx_q <= idx_q + 8'd1;
                end else begin
                    active_o <= 1'b0;
                    idx_q    <= '0;
                    if ({byte_i, lo_q} == crc_q) begin
                        evt_o <= RXE_GOOD;
                        len_o <= PLEN_W'(cnt_q - 8'd3);
                    end else begin
                        evt_o <= RXE_BAD;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (active_o && valid_i && !start_i && in_pkt) mem_q[widx] <= byte_i;
    end

    for (genvar g = 0; g < PKT_MAX; g++) begin : g_flat
        assign data_o[g*8 +: 8] = mem_q[g];
    end

    // R7
    count_range_chk: assert property (@(posedge clk) disable iff (rst || clear_i)
        (active_o && valid_i && !start_i && idx_q == 8'd0 &&
         (byte_i < 8'(MIN_LEN) || byte_i > 8'(MAX_LEN)))
        |=> (evt_o == RXE_BAD && !active_o));

endmodule

// File: rtl/frm_tx.sv
module frm_tx
    import frm_pkg::*;
#(
    parameter int RSP_MAX = 4,
    localparam int LEN_W  = $clog2(RSP_MAX + 1),
    localparam int RIDX_W = (RSP_MAX > 1) ? $clog2(RSP_MAX) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear_i,
    input  logic                  start_i,
    input  logic [LEN_W-1:0]      len_i,
    input  logic [RSP_MAX*8-1:0]  data_i,
    input  logic                  ready_i,
    output logic [7:0]            byte_o,
    output logic                  valid_o
);

    logic [7:0]  idx_q;
    logic [15:0] crc_q;
    logic [7:0]  len8;
    logic [7:0]  total;
    logic [7:0]  rb [RSP_MAX];

    for (genvar g = 0; g < RSP_MAX; g++) begin : g_bytes
        assign rb[g] = data_i[g*8 +: 8];
    end

    always_comb begin
        len8  = 8'(len_i);
        total = len8 + 8'd3;
        if (idx_q == 8'd0)              byte_o = total;
        else if (idx_q <= len8)         byte_o = rb[RIDX_W'(idx_q - 8'd1)];
        else if (idx_q == len8 + 8'd1)  byte_o = crc_q[7:0];
        else                            byte_o = crc_q[15:8];
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            valid_o <= 1'b0;
            idx_q   <= '0;
            crc_q   <= '0;
        end else if (!valid_o && start_i) begin
            valid_o <= 1'b1;
            idx_q   <= '0;
            crc_q   <= '0;
        end else if (valid_o && ready_i) begin
            if (idx_q <= len8) crc_q <= crc16_step(crc_q, byte_o);
            if (idx_q == total - 8'd1) valid_o <= 1'b0;
            else                       idx_q   <= idx_q + 8'd1;
        end
    end

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst || clear_i)
        (valid_o && !ready_i) |=> (valid_o && $stable(byte_o)));

    // R10
    first_count_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> (byte_o == 8'(len_i) + 8'd3));

endmodule

// File: rtl/cmd_block_framer.sv
module cmd_block_framer
    import frm_pkg::*;
#(
    parameter int RSP_MAX = 4,
    parameter int MIN_LEN = BLK_MIN,
    parameter int MAX_LEN = BLK_MAX,
    localparam int PKT_MAX = MAX_LEN - OVH,
    localparam int PLEN_W  = $clog2(PKT_MAX + 1),
    localparam int LEN_W   = $clog2(RSP_MAX + 1),
    localparam int RSP_W   = RSP_MAX * 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wake_i,
    input  logic [7:0]            rx_byte_i,
    input  logic                  rx_valid_i,
    output logic [7:0]            tx_byte_o,
    output logic                  tx_valid_o,
    input  logic                  tx_ready_i,
    output logic [PKT_MAX*8-1:0]  pkt_data_o,
    output logic [PLEN_W-1:0]     pkt_len_o,
    output logic                  pkt_valid_o,
    input  logic [RSP_W-1:0]      rsp_data_i,
    input  logic [LEN_W-1:0]      rsp_len_i,
    input  logic                  rsp_valid_i,
    input  logic                  exec_err_i,
    output logic                  sleep_o
);

    rpl_e             kind_q;
    logic [LEN_W-1:0] rlen_q;
    logic [RSP_W-1:0] rdat_q;
    rx_evt_e          rx_evt;
    logic             rx_act;
    logic             flag_ok, cmd_go, xmt_go, slp_go;

    always_comb begin
        flag_ok = rx_valid_i && !rx_act && !tx_valid_o && !wake_i;
        cmd_go  = flag_ok && (rx_byte_i == FLG_CMD);
        xmt_go  = flag_ok && (rx_byte_i == FLG_XMT) && (kind_q == RPL_READY);
        slp_go  = flag_ok && (rx_byte_i == FLG_SLP);
    end

    frm_rx #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (wake_i),
        .start_i  (cmd_go),
        .byte_i   (rx_byte_i),
        .valid_i  (rx_valid_i),
        .active_o (rx_act),
        .evt_o    (rx_evt),
        .len_o    (pkt_len_o),
        .data_o   (pkt_data_o)
    );

    frm_tx #(.RSP_MAX(RSP_MAX)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .clear_i (wake_i),
        .start_i (xmt_go),
        .len_i   (rlen_q),
        .data_i  (rdat_q),
        .ready_i (tx_ready_i),
        .byte_o  (tx_byte_o),
        .valid_o (tx_valid_o)
    );

    assign pkt_valid_o = (rx_evt == RXE_GOOD);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= RPL_NONE;
            rlen_q  <= '0;
            rdat_q  <= '0;
            sleep_o <= 1'b0;
        end else begin
            sleep_o <= slp_go;
            if (wake_i) begin
                kind_q <= RPL_READY;
                rlen_q <= LEN_W'(1);
                rdat_q <= RSP_W'(ST_WAKE);
            end else if (slp_go || cmd_go) begin
                kind_q <= RPL_NONE;
            end else if (rx_evt == RXE_BAD) begin
                kind_q <= RPL_READY;
                rlen_q <= LEN_W'(1);
                rdat_q <= RSP_W'(ST_COMM);
            end else if (rx_evt == RXE_GOOD) begin
                kind_q <= RPL_WAIT;
            end else if (kind_q == RPL_WAIT && exec_err_i) begin
                kind_q <= RPL_READY;
                rlen_q <= LEN_W'(1);
                rdat_q <= RSP_W'(ST_EXEC);
            end else if (kind_q == RPL_WAIT && rsp_valid_i) begin
                kind_q <= RPL_READY;
                rlen_q <= rsp_len_i;
                rdat_q <= rsp_data_i;
            end
        end
    end

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_q == RPL_WAIT && rx_valid_i && rx_byte_i == FLG_XMT) |=> !tx_valid_o);

    // R13
    sleep_src_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_o |-> $past(rx_valid_i && rx_byte_i == FLG_SLP));

    // R4
    pkt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_valid_o |=> !pkt_valid_o);

endmodule

// File: tb/tb_cmd_block_framer.sv
module tb_cmd_block_framer;

    logic         clk = 1'b0;
    logic         rst;
    logic         wake_i;
    logic [7:0]   rx_byte_i;
    logic         rx_valid_i;
    logic [7:0]   tx_byte_o;
    logic         tx_valid_o;
    logic         tx_ready_i;
    logic [287:0] pkt_data_o;
    logic [5:0]   pkt_len_o;
    logic         pkt_valid_o;
    logic [31:0]  rsp_data_i;
    logic [2:0]   rsp_len_i;
    logic         rsp_valid_i;
    logic         exec_err_i;
    logic         sleep_o;

    always #2 clk = ~clk;

    cmd_block_framer dut (.*);

    logic [7:0]   exp_q[$];
    logic [7:0]   pq[$];
    int           checks = 0;
    int           fails = 0;
    int           pkt_cnt = 0;
    int           slp_cnt = 0;
    logic [5:0]   last_len;
    logic [287:0] last_data;
    string        cur_req = "R1";
    bit           done = 0;
    bit           hold_v = 0;
    logic [7:0]   hold_b;

    function automatic logic [15:0] ref_crc(input logic [7:0] q[$]);
        logic [15:0] c = 16'h0000;
        foreach (q[k]) begin
            for (int i = 0; i < 8; i++) begin
                if (c[15] != q[k][i]) c = (c << 1) ^ 16'h8005;
                else                  c = c << 1;
            end
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor: scoreboard pop on every accepted reply byte
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_v && tx_valid_o)
                check(tx_byte_o == hold_b, "R11", "byte changed under stall", tx_byte_o, hold_b);
            hold_v = tx_valid_o && !tx_ready_i;
            hold_b = tx_byte_o;
            if (tx_valid_o && tx_ready_i) begin
                if (exp_q.size() == 0) begin
                    check(0, cur_req, "unexpected reply byte", tx_byte_o, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(tx_byte_o == e, cur_req, "reply byte", tx_byte_o, e);
                end
            end
            if (pkt_valid_o) begin
                pkt_cnt++;
                last_len  = pkt_len_o;
                last_data = pkt_data_o;
            end
            if (sleep_o) slp_cnt++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] b);
        rx_byte_i  = b;
        rx_valid_i = 1'b1;
        tick();
        rx_valid_i = 1'b0;
        tick();
    endtask

    task automatic send_blk(input logic [7:0] p[$], input bit corrupt);
        logic [7:0]  blk[$];
        logic [15:0] c;
        blk = p;
        blk.push_front(8'(p.size() + 3));
        c = ref_crc(blk);
        if (corrupt) c = c ^ 16'h0100;
        foreach (blk[k]) send(blk[k]);
        send(c[7:0]);
        send(c[15:8]);
    endtask

    task automatic expect_blk(input logic [7:0] p[$]);
        logic [7:0]  blk[$];
        logic [15:0] c;
        blk = p;
        blk.push_front(8'(p.size() + 3));
        c = ref_crc(blk);
        foreach (blk[k]) exp_q.push_back(blk[k]);
        exp_q.push_back(c[7:0]);
        exp_q.push_back(c[15:8]);
    endtask

    task automatic drain(input string req);
        for (int n = 0; n < 300 && (exp_q.size() != 0 || tx_valid_o); n++) tick();
        repeat (10) tick();
        check(exp_q.size() == 0, req, "expected bytes left", exp_q.size(), 0);
    endtask

    task automatic wake();
        wake_i = 1'b1;
        tick();
        wake_i = 1'b0;
        tick();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        int pc;
        rst = 1'b1; wake_i = 0; rx_byte_i = 0; rx_valid_i = 0; tx_ready_i = 1;
        rsp_data_i = 0; rsp_len_i = 0; rsp_valid_i = 0; exec_err_i = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: idle outputs, transmit flag before wake gives nothing
        cur_req = "R1";
        check(tx_valid_o == 0, "R1", "tx_valid after reset", tx_valid_o, 0);
        check(pkt_valid_o == 0, "R1", "pkt_valid after reset", pkt_valid_o, 0);
        check(sleep_o == 0, "R1", "sleep after reset", sleep_o, 0);
        send(8'h99);
        drain("R1");

        // R2 and R5: wake status block with CRC low then high
        cur_req = "R2";
        wake();
        pq = {8'h11}; expect_blk(pq);
        send(8'h99);
        drain("R2");

        // R3: reserved flags
        cur_req = "R3";
        pq = {8'h00, 8'h12, 8'h65, 8'h67, 8'h98, 8'h9A, 8'hCB, 8'hCD, 8'hFF, 8'h04};
        foreach (pq[k]) send(pq[k]);
        drain("R3");
        check(slp_cnt == 0, "R3", "sleep pulses", slp_cnt, 0);
        check(pkt_cnt == 0, "R3", "packet strobes", pkt_cnt, 0);

        // R4: good command block
        cur_req = "R4";
        send(8'h66);
        pq = {8'h08, 8'h01, 8'h00, 8'h00};
        send_blk(pq, 0);
        tick();
        check(pkt_cnt == 1, "R4", "packet strobes", pkt_cnt, 1);
        check(last_len == 6'd4, "R4", "packet length", last_len, 4);
        check(last_data[31:0] == 32'h0000_0108, "R4", "packet bytes", last_data[31:0], 32'h108);

        // R8: flag while busy, and flag coincident with engine result
        cur_req = "R8";
        send(8'h99);
        repeat (10) tick();
        rsp_data_i = 32'h0000_55AA; rsp_len_i = 3'd2;
        rx_byte_i = 8'h99; rx_valid_i = 1; rsp_valid_i = 1;
        tick();
        rx_valid_i = 0; rsp_valid_i = 0;
        repeat (10) tick();
        drain("R8");

        // R10: response block, read twice
        cur_req = "R10";
        pq = {8'hAA, 8'h55}; expect_blk(pq);
        send(8'h99);
        drain("R10");
        rsp_data_i = 32'h0;
        expect_blk(pq);

        // R11 and R12: stalled re-read with bytes arriving during the reply
        tx_ready_i = 0;
        send(8'h99);
        repeat (4) tick();
        check(tx_valid_o == 1, "R11", "valid held under stall", tx_valid_o, 1);
        cur_req = "R12";
        send(8'h99);
        send(8'hCC);
        send(8'h66);
        tx_ready_i = 1;
        drain("R12");
        check(slp_cnt == 0, "R12", "sleep during reply", slp_cnt, 0);

        // R9: execution error
        cur_req = "R9";
        send(8'h66);
        pq = {8'h40, 8'h20, 8'h00, 8'h00, 8'h5A};
        send_blk(pq, 0);
        exec_err_i = 1; tick(); exec_err_i = 0; tick();
        check(pkt_cnt == 2, "R9", "packet strobes", pkt_cnt, 2);
        pq = {8'h0F}; expect_blk(pq);
        send(8'h99);
        drain("R9");

        // R6: bad CRC
        cur_req = "R6";
        send(8'h66);
        pq = {8'h08, 8'h00, 8'h01, 8'h00};
        send_blk(pq, 1);
        tick();
        check(pkt_cnt == 2, "R6", "packet strobes", pkt_cnt, 2);
        pq = {8'hFF}; expect_blk(pq);
        send(8'h99);
        drain("R6");

        // R7: length out of range, next byte decoded as flag
        cur_req = "R7";
        send(8'h66);
        send(8'h03);
        pq = {8'hFF}; expect_blk(pq);
        send(8'h99);
        drain("R7");
        send(8'h66);
        send(8'h28);
        expect_blk(pq);
        send(8'h99);
        drain("R7");
        check(pkt_cnt == 2, "R7", "packet strobes", pkt_cnt, 2);

        // R4 boundaries: 39-byte and 4-byte blocks
        cur_req = "R4";
        send(8'h66);
        pq = {};
        for (int k = 0; k < 36; k++) pq.push_back(8'(k * 7 + 3));
        send_blk(pq, 0);
        tick();
        check(pkt_cnt == 3, "R4", "max block strobe", pkt_cnt, 3);
        check(last_len == 6'd36, "R4", "max block length", last_len, 36);
        check(last_data[287:280] == 8'd248, "R4", "last packet byte", last_data[287:280], 248);
        check(last_data[7:0] == 8'd3, "R4", "first packet byte", last_data[7:0], 3);
        send(8'h66);
        pq = {8'hC3};
        send_blk(pq, 0);
        tick();
        check(pkt_cnt == 4, "R4", "min block strobe", pkt_cnt, 4);
        check(last_len == 6'd1, "R4", "min block length", last_len, 1);
        check(last_data[7:0] == 8'hC3, "R4", "min block byte", last_data[7:0], 8'hC3);

        // R13: sleep
        cur_req = "R13";
        pc = slp_cnt;
        send(8'hCC);
        check(slp_cnt == pc + 1, "R13", "sleep pulse cycles", slp_cnt - pc, 1);
        send(8'h99);
        drain("R13");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule